// File: doc/BRIEF.md
# Coprocessor Instruction Trap Arbiter

This block sits next to a CPU that issues coprocessor escape instructions and WAIT instructions. For every instruction the CPU presents, it decides whether a trap must be taken and which vector to raise. The inputs are the instruction class, the emulate and task-switched control bits, a locally held pending-error flag, the protected-mode flag, and the operand's segment description and placement. The answer is one registered strobe with an 8-bit vector number, one clock after the instruction is presented.

Four causes are arbitrated. The first is "coprocessor not available" (vector 7). The second is "previous numeric error pending" (vector 16). The third is "first operand word outside the segment" (vector 13). The fourth is "operand overruns the segment past its first word", which includes wrapping around the address space (vector 9). A pulse input records a pending unmasked numeric error. A clear input models the no-wait initialise or clear-exceptions instructions. The no-wait control forms are exempt from the pending-error trap, so a handler can always reach the coprocessor to clean up.

Top module: `cop_trap_arbiter`

## Requirements
- R1: After synchronous reset, `trap_stb` is 0, `trap_vec` is 0 and the pending-error flag is clear.
- R2: The result for an instruction presented with `ins_valid`=1 appears on `trap_stb`/`trap_vec` exactly one clock later. A cycle with `ins_valid`=0 gives `trap_stb`=0 on the next clock. `trap_vec` is 0 whenever `trap_stb` is 0.
- R3: Class encoding on `ins_class`: 0 = escape with wait, 1 = WAIT, 2 = no-wait control escape, 3 = non-coprocessor. Vector 7 is raised for class 0 or 2 when `cr0_em` or `cr0_ts` is 1. It is raised for class 1 only when `cr0_ts` is 1; `cr0_em` alone never traps a WAIT.
- R4: Vector 16 is raised for class 0 or 1 while the pending-error flag is set. Class 2 never raises vector 16, even with the flag set.
- R5: `exc_pulse` sets the pending-error flag and `pend_clr` clears it, effective for instructions presented from the next clock on. When both are high in one cycle, the clear wins.
- R6: Operand byte k lies at offset (`op_offset`+k) mod 65536. Such a byte is valid when its offset is ≤ `seg_limit` for an expand-up segment (`seg_down`=0), and > `seg_limit` for an expand-down segment (`seg_down`=1). In protected mode (`pmode`=1), class 0 or 2 raises vector 13 when byte 0 or byte 1 is invalid.
- R7: In protected mode, class 0 or 2 raises vector 9 when bytes 0 and 1 are valid but a later byte of the operand is invalid. This covers an operand that wraps past offset 0xFFFF: an 8-byte operand at 0xFFFC with expand-up limit 0xFFFD gives vector 9.
- R8: `op_len` gives the operand size: 0 = 2 bytes, 1 = 4 bytes, 2 = 8 bytes, 3 = 10 bytes. Only bytes inside that size take part in the checks of R6 and R7.
- R9: With `pmode`=0, vectors 13 and 9 are never raised. WAIT (class 1) never raises them. Class 3 never raises any vector.
- R10: When several causes apply, exactly one vector is reported, chosen in the order 7, then 16, then 13, then 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | An instruction is presented this cycle |
| ins_class | input | 2 | Instruction class (encoding in R3) |
| cr0_em | input | 1 | Emulate-coprocessor control bit |
| cr0_ts | input | 1 | Task-switched control bit |
| exc_pulse | input | 1 | Records a pending unmasked numeric error |
| pend_clr | input | 1 | Clears the pending-error flag |
| pmode | input | 1 | Protected mode is active |
| seg_down | input | 1 | Segment is expand-down |
| seg_limit | input | 16 | Segment limit |
| op_offset | input | 16 | Operand start offset |
| op_len | input | 2 | Operand size code (R8) |
| trap_stb | output | 1 | One-cycle trap strobe |
| trap_vec | output | 8 | Vector number of the trap, 0 when none |

## Verification
The only state inside the block is the pending-error flag and the output register. A flag that is set or cleared wrongly appears as a missing or unwanted vector 16 on the very next WAIT or waiting escape. An output register that holds over, or that strobes while idle, is visible one clock after any idle cycle. The limit logic holds no state, so a bad byte comparison shows up as a wrong 9, 13 or 0 for that one instruction. The sweep therefore crosses offsets near both ends of the address space with limits near those ends, for both segment directions and every operand size. Each of these combinations is repeated for every class, control-bit pair and mode, with the pending flag both clear and set.

// File: rtl/cop_trap_pkg.sv
package cop_trap_pkg;

  typedef enum logic [1:0] {
    CLS_ESC  = 2'd0,
    CLS_WAIT = 2'd1,
    CLS_CTRL = 2'd2,
    CLS_NONE = 2'd3
  } ins_cls_e;

  localparam int unsigned VEC_NOTAVAIL = 7;
  localparam int unsigned VEC_OVERRUN  = 9;
  localparam int unsigned VEC_FIRSTWD  = 13;
  localparam int unsigned VEC_PENDING  = 16;

  // Operand size code to byte count.
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    case (code)
      2'd0:    len_bytes = 4'd2;
      2'd1:    len_bytes = 4'd4;
      2'd2:    len_bytes = 4'd8;
      default: len_bytes = 4'd10;
    endcase
  endfunction

endpackage

// File: rtl/cop_pend_flag.sv
module cop_pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  always_ff @(posedge clk) begin
    if (rst)        pend_o <= 1'b0;
    else if (clr_i) pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !pend_o); // R5
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> pend_o); // R5

endmodule

// File: rtl/cop_limit_check.sv
module cop_limit_check #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MAX_BYTES = 10
) (
  input  logic              seg_down,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic [ADDR_W-1:0] op_offset,
  input  logic [1:0]        op_len,
  output logic              first_bad,
  output logic              tail_bad
);
  import cop_trap_pkg::*;

  localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1);

  logic [CNT_W-1:0]     nbytes;
  logic [MAX_BYTES-1:0] bad;
  logic [MAX_BYTES-1:0] active;

  assign nbytes = CNT_W'(len_bytes(op_len));

  // One comparator per operand byte; the address wraps at ADDR_W bits.
  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
    logic [ADDR_W-1:0] addr;
    assign addr      = op_offset + ADDR_W'(i);
    assign bad[i]    = seg_down ? (addr <= seg_limit) : (addr > seg_limit);
    assign active[i] = (CNT_W'(i) < nbytes);
  end

  assign first_bad = bad[0] | bad[1];
  assign tail_bad  = !first_bad && (|(bad[MAX_BYTES-1:2] & active[MAX_BYTES-1:2]));

endmodule

// File: rtl/cop_trap_prio.sv
module cop_trap_prio #(
  parameter int unsigned VEC_W = 8
) (
  input  cop_trap_pkg::ins_cls_e cls,
  input  logic                   em,
  input  logic                   ts,
  input  logic                   pend,
  input  logic                   pmode,
  input  logic                   first_bad,
  input  logic                   tail_bad,
  output logic                   hit,
  output logic [VEC_W-1:0]       vec
);
  import cop_trap_pkg::*;

  logic is_cop, t_na, t_pend, t_first, t_over;

  assign is_cop  = (cls == CLS_ESC) || (cls == CLS_CTRL);
  assign t_na    = (is_cop && (em || ts)) || ((cls == CLS_WAIT) && ts);
  assign t_pend  = ((cls == CLS_ESC) || (cls == CLS_WAIT)) && pend;
  assign t_first = is_cop && pmode && first_bad;
  assign t_over  = is_cop && pmode && tail_bad;

  always_comb begin
    hit = 1'b1;
    if (t_na)         vec = VEC_W'(VEC_NOTAVAIL);
    else if (t_pend)  vec = VEC_W'(VEC_PENDING);
    else if (t_first) vec = VEC_W'(VEC_FIRSTWD);
    else if (t_over)  vec = VEC_W'(VEC_OVERRUN);
    else begin
      hit = 1'b0;
      vec = '0;
    end
  end

endmodule

// File: rtl/cop_trap_arbiter.sv
module cop_trap_arbiter #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MAX_BYTES = 10,
  parameter int unsigned VEC_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [1:0]        ins_class,
  input  logic              cr0_em,
  input  logic              cr0_ts,
  input  logic              exc_pulse,
  input  logic              pend_clr,
  input  logic              pmode,
  input  logic              seg_down,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic [ADDR_W-1:0] op_offset,
  input  logic [1:0]        op_len,
  output logic              trap_stb,
  output logic [VEC_W-1:0]  trap_vec
);
  import cop_trap_pkg::*;

  ins_cls_e         cls;
  logic             pend_q;
  logic             first_bad, tail_bad;
  logic             hit;
  logic [VEC_W-1:0] vec_c;

  assign cls = ins_cls_e'(ins_class);

  cop_pend_flag u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (exc_pulse),
    .clr_i  (pend_clr),
    .pend_o (pend_q)
  );

  cop_limit_check #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_lim (
    .seg_down  (seg_down),
    .seg_limit (seg_limit),
    .op_offset (op_offset),
    .op_len    (op_len),
    .first_bad (first_bad),
    .tail_bad  (tail_bad)
  );

  cop_trap_prio #(.VEC_W(VEC_W)) u_prio (
    .cls       (cls),
    .em        (cr0_em),
    .ts        (cr0_ts),
    .pend      (pend_q),
    .pmode     (pmode),
    .first_bad (first_bad),
    .tail_bad  (tail_bad),
    .hit       (hit),
    .vec       (vec_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_stb <= 1'b0;
      trap_vec <= '0;
    end else begin
      trap_stb <= ins_valid && hit;
      trap_vec <= (ins_valid && hit) ? vec_c : '0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |=> (!trap_stb && trap_vec == '0)); // R2
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    trap_stb |-> (trap_vec == VEC_W'(7) || trap_vec == VEC_W'(9) ||
                  trap_vec == VEC_W'(13) || trap_vec == VEC_W'(16))); // R10
  AST_WAIT_EM_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && cls == CLS_WAIT && cr0_em && !cr0_ts && !pend_q) |=> !trap_stb); // R3
  AST_CTRL_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && cls == CLS_CTRL) |=> (trap_vec != VEC_W'(16))); // R4
  AST_REAL_NO_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !pmode) |=> (trap_vec != VEC_W'(9) && trap_vec != VEC_W'(13))); // R9
  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({first_bad, tail_bad})); // R7

endmodule

// File: tb/test_cop_trap_arbiter.sv
`timescale 1ns/1ps
module test_cop_trap_arbiter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic [1:0]  ins_class = 2'd3;
  logic        cr0_em = 1'b0, cr0_ts = 1'b0;
  logic        exc_pulse = 1'b0, pend_clr = 1'b0;
  logic        pmode = 1'b0, seg_down = 1'b0;
  logic [15:0] seg_limit = 16'hFFFF, op_offset = 16'h0;
  logic [1:0]  op_len = 2'd0;
  logic        trap_stb;
  logic [7:0]  trap_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cop_trap_arbiter i_cop_trap_arbiter (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_class(ins_class),
    .cr0_em(cr0_em), .cr0_ts(cr0_ts), .exc_pulse(exc_pulse), .pend_clr(pend_clr),
    .pmode(pmode), .seg_down(seg_down), .seg_limit(seg_limit),
    .op_offset(op_offset), .op_len(op_len), .trap_stb(trap_stb), .trap_vec(trap_vec)
  );

  function automatic int nb(input logic [1:0] c);
    case (c)
      2'd0: nb = 2;
      2'd1: nb = 4;
      2'd2: nb = 8;
      default: nb = 10;
    endcase
  endfunction

  // Expected vector per the requirements; 0 means no trap.
  function automatic int model(input int cls, input bit em, input bit ts, input bit pend,
                               input bit pm, input bit dn, input int lim, input int off,
                               input logic [1:0] lc);
    bit cop, fb, tb;
    cop = (cls == 0) || (cls == 2);
    fb = 1'b0; tb = 1'b0;
    for (int k = 0; k < nb(lc); k++) begin
      int a;
      bit ok;
      a  = (off + k) % 65536;
      ok = dn ? (a > lim) : (a <= lim);
      if (!ok) begin
        if (k < 2) fb = 1'b1; else tb = 1'b1;
      end
    end
    if ((cop && (em || ts)) || (cls == 1 && ts)) return 7;
    if ((cls == 0 || cls == 1) && pend)         return 16;
    if (cop && pm && fb)                        return 13;
    if (cop && pm && tb)                        return 9;
    return 0;
  endfunction

  task automatic check(input string tag, input int exp);
    int got;
    got = trap_stb ? int'(trap_vec) : 0;
    checks++;
    if (got != exp || (!trap_stb && trap_vec != 0)) begin
      fails++;
      $display("FAIL %s: stb=%0d vec=%0d expected vec=%0d", tag, trap_stb, trap_vec, exp);
    end
  endtask

  task automatic issue(input int cls, input bit em, input bit ts, input bit pm, input bit dn,
                       input int lim, input int off, input logic [1:0] lc,
                       input string tag, input int exp);
    @(negedge clk);
    ins_valid = 1'b1; ins_class = 2'(cls); cr0_em = em; cr0_ts = ts; pmode = pm;
    seg_down = dn; seg_limit = 16'(lim); op_offset = 16'(off); op_len = lc;
    @(negedge clk);
    ins_valid = 1'b0;
    check(tag, exp);
  endtask

  task automatic pulse(input bit s, input bit c);
    @(negedge clk);
    exc_pulse = s; pend_clr = c;
    @(negedge clk);
    exc_pulse = 1'b0; pend_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int offs[7];
    int lims[4];
    offs = '{0, 1, 'h7FFE, 'hFFF6, 'hFFFC, 'hFFFE, 'hFFFF};
    lims = '{0, 'h7FFF, 'hFFFD, 'hFFFF};

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset outputs", 0);
    // Pending flag must be clear after reset: WAIT with no control bits set.
    issue(1, 0, 0, 0, 0, 'hFFFF, 0, 0, "R1 pending clear after reset", 0);

    // R2: idle cycles with trap-inducing inputs produce no strobe.
    @(negedge clk);
    ins_valid = 1'b0; ins_class = 2'd0; cr0_em = 1'b1; cr0_ts = 1'b1;
    @(negedge clk);
    check("R2 idle no strobe", 0);
    @(negedge clk);
    check("R2 idle no strobe 2", 0);

    // R5: set, clear, simultaneous set+clear.
    pulse(1, 0);
    issue(1, 0, 0, 0, 0, 'hFFFF, 0, 0, "R5 set then WAIT", 16);
    issue(2, 0, 0, 0, 0, 'hFFFF, 0, 0, "R4 control form exempt", 0);
    pulse(0, 1);
    issue(0, 0, 0, 0, 0, 'hFFFF, 0, 0, "R5 cleared then ESC", 0);
    pulse(1, 0);
    pulse(1, 1);
    issue(1, 0, 0, 0, 0, 'hFFFF, 0, 0, "R5 clear wins", 0);

    // R7 worked example, R6 first-word fault, R3 EM-only WAIT.
    issue(0, 0, 0, 1, 0, 'hFFFD, 'hFFFC, 2, "R7 wrap example", 9);
    issue(0, 0, 0, 1, 0, 'h0010, 'h0010, 0, "R6 second byte out", 13);
    issue(1, 1, 0, 1, 0, 'h0000, 'hFFFF, 3, "R3 EM alone on WAIT", 0);
    issue(3, 1, 1, 1, 0, 'h0000, 'hFFFF, 3, "R9 non-coprocessor class", 0);
    issue(2, 0, 0, 1, 1, 'h0004, 'h0005, 1, "R8 expand-down 4 bytes ok", 0);

    // Sweep: R3 R4 R6 R7 R8 R9 R10 across every combination.
    for (int p = 0; p < 2; p++) begin
      if (p == 1) pulse(1, 0); else pulse(0, 1);
      for (int c = 0; c < 4; c++)
        for (int e = 0; e < 2; e++)
          for (int t = 0; t < 2; t++)
            for (int m = 0; m < 2; m++)
              for (int d = 0; d < 2; d++)
                for (int l = 0; l < 4; l++)
                  for (int o = 0; o < 7; o++)
                    for (int q = 0; q < 4; q++)
                      issue(c, e[0], t[0], m[0], d[0], lims[q], offs[o], 2'(l),
                            "R3 R4 R6 R7 R8 R9 R10 sweep",
                            model(c, e[0], t[0], p[0], m[0], d[0], lims[q], offs[o], 2'(l)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule